// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between the controller's transmit data line and the enable of a single-wire bus driver. While normal mode is active, a low transmit level pulls the bus dominant and a high level leaves it recessive. The guard stops two faults. One is a transmit line stuck low, which would hold the bus dominant forever. The other is a transmit line that is already low when normal mode starts, which would drive a false dominant level at once.

Time is measured in ticks of an external time base. If the transmit line stays low for a set number of ticks, the driver is forced recessive and a time-out flag is raised. The mode controller uses this flag, for example to allow a sleep request while the line is still held low. Once the driver is locked, it is released only after the transmit line has been high for a set number of ticks without a break. The same lock applies when normal mode is entered with the line low, but in that case the flag is not raised. When normal mode is off, the driver is recessive and all guard state is cleared.

Top module: `txd_dom_guard`

## Requirements
- R1: While normal mode is active and the guard is armed, `drvDominant` equals the inverse of `txdIn` in the same cycle: 1 means the bus is driven dominant, 0 means recessive.
- R2: While armed, if `txdIn` is low on TIMEOUT_TICKS consecutive tick cycles without going high, then from the next cycle `drvDominant` is 0 and `timeoutFlag` is 1.
- R3: After a time-out, the driver is re-enabled only once `txdIn` has been high on REARM_TICKS tick cycles with no low level in between. Any low cycle restarts that count. The guard is armed again from the cycle after the last counted tick.
- R4: If `txdIn` is low on the first clock edge of normal mode, the guard starts locked. `drvDominant` stays 0 until the re-arm condition of R3 is met, and `timeoutFlag` stays 0 throughout.
- R5: After reset, and whenever `normalActive` is 0, `drvDominant` is 0. On the edge where `normalActive` is sampled 0, `timeoutFlag` and both counts are cleared. The first cycle of normal mode is always recessive.
- R6: `timeoutFlag`, once set, stays 1 until the re-arm condition is met or normal mode ends.
- R7: Cycles without `tick` do not advance either count, so a low `txdIn` with no ticks never causes a time-out.
- R8: While armed, a single high cycle on `txdIn` restarts the low-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txdIn | input | 1 | Transmit data from the controller; 0 requests dominant |
| normalActive | input | 1 | Normal mode is active |
| tick | input | 1 | One-cycle time base strobe |
| drvDominant | output | 1 | Driver command; 1 drives the bus dominant |
| timeoutFlag | output | 1 | Dominant time-out has expired and re-arm is pending |

## Verification
The bench builds the guard with TIMEOUT_TICKS = 8 and REARM_TICKS = 3, instead of the default tens of thousands of microsecond ticks. With these values, random stuck-low runs reach a time-out and the re-arm window within a few dozen cycles. Ticks arrive on about half the cycles, so tickless stretches occur and the R7 rule gets exercised. Rare drops of normal mode cover both the clearing path and entry with the line held low.

// File: rtl/txguard_pkg.sv
package txguard_pkg;

  typedef enum logic [1:0] {
    GM_OFF    = 2'd0,
    GM_ARMED  = 2'd1,
    GM_LOCKED = 2'd2
  } guardMode_e;

  // strobes from control to counter datapath
  typedef struct packed {
    logic lowClr;
    logic lowInc;
    logic highClr;
    logic highInc;
  } cntCtl_s;

endpackage

// File: rtl/txguard_satcnt.sv
module txguard_satcnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic atLimit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  // the next counted tick completes the window
  assign atLimit = (cnt >= CNT_LAST);
endmodule

// File: rtl/txguard_cnt.sv
module txguard_cnt
  import txguard_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 40000,
  parameter int unsigned REARM_TICKS   = 11
) (
  input  logic    clk,
  input  logic    rst_n,
  input  cntCtl_s ctl,
  output logic    lowAtLimit,
  output logic    highAtLimit
);
  localparam int unsigned N_CNT = 2;

  logic [N_CNT-1:0] clrV, incV, atV;

  assign clrV = {ctl.highClr, ctl.lowClr};
  assign incV = {ctl.highInc, ctl.lowInc};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    localparam int unsigned LIM = (g == 0) ? TIMEOUT_TICKS : REARM_TICKS;
    txguard_satcnt #(.LIMIT(LIM)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clrV[g]),
      .inc    (incV[g]),
      .atLimit(atV[g])
    );
  end

  assign lowAtLimit  = atV[0];
  assign highAtLimit = atV[1];
endmodule

// File: rtl/txguard_ctl.sv
module txguard_ctl
  import txguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txdIn,
  input  logic       normalActive,
  input  logic       tick,
  input  logic       lowAtLimit,
  input  logic       highAtLimit,
  output cntCtl_s    ctl,
  output logic       drvDominant,
  output logic       timeoutFlag
);
  guardMode_e mode, nextMode;
  logic       flag, nextFlag;

  always_comb begin
    ctl      = '0;
    nextMode = mode;
    nextFlag = flag;
    if (!normalActive) begin
      nextMode    = GM_OFF;
      nextFlag    = 1'b0;
      ctl.lowClr  = 1'b1;
      ctl.highClr = 1'b1;
    end else begin
      unique case (mode)
        GM_OFF: begin
          nextMode    = txdIn ? GM_ARMED : GM_LOCKED;
          ctl.lowClr  = 1'b1;
          ctl.highClr = 1'b1;
        end
        GM_ARMED: begin
          if (txdIn) begin
            ctl.lowClr = 1'b1;
          end else if (tick) begin
            if (lowAtLimit) begin
              nextMode    = GM_LOCKED;
              nextFlag    = 1'b1;
              ctl.lowClr  = 1'b1;
              ctl.highClr = 1'b1;
            end else begin
              ctl.lowInc = 1'b1;
            end
          end
        end
        GM_LOCKED: begin
          if (!txdIn) begin
            ctl.highClr = 1'b1;
          end else if (tick) begin
            if (highAtLimit) begin
              nextMode    = GM_ARMED;
              nextFlag    = 1'b0;
              ctl.lowClr  = 1'b1;
              ctl.highClr = 1'b1;
            end else begin
              ctl.highInc = 1'b1;
            end
          end
        end
        default: nextMode = GM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= GM_OFF;
      flag <= 1'b0;
    end else begin
      mode <= nextMode;
      flag <= nextFlag;
    end
  end

  assign drvDominant = normalActive && (mode == GM_ARMED) && !txdIn;
  assign timeoutFlag = flag;
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
  import txguard_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 40000,
  parameter int unsigned REARM_TICKS   = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txdIn,
  input  logic normalActive,
  input  logic tick,
  output logic drvDominant,
  output logic timeoutFlag
);
  cntCtl_s ctl;
  logic    lowAtLimit, highAtLimit;

  txguard_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .txdIn       (txdIn),
    .normalActive(normalActive),
    .tick        (tick),
    .lowAtLimit  (lowAtLimit),
    .highAtLimit (highAtLimit),
    .ctl         (ctl),
    .drvDominant (drvDominant),
    .timeoutFlag (timeoutFlag)
  );

  txguard_cnt #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .REARM_TICKS  (REARM_TICKS)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .lowAtLimit (lowAtLimit),
    .highAtLimit(highAtLimit)
  );
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic txdIn,
  input logic normalActive,
  input logic tick,
  input logic drvDominant,
  input logic timeoutFlag
);
  AST_FLAG_BLOCKS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutFlag |-> !drvDominant); // R2

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutFlag) |-> $past(!txdIn && tick && normalActive)); // R2

  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeoutFlag) |-> ($past(txdIn && tick) || !$past(normalActive))); // R6

  AST_OFF_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(normalActive) |-> !timeoutFlag); // R5

  AST_NO_TICK_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tick) |-> !$rose(timeoutFlag)); // R7

  AST_DRV_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drvDominant |-> (!txdIn && normalActive)); // R1
endmodule

bind txd_dom_guard txd_dom_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txdIn       (txdIn),
  .normalActive(normalActive),
  .tick        (tick),
  .drvDominant (drvDominant),
  .timeoutFlag (timeoutFlag)
);

// File: tb/sim_txd_dom_guard.sv
`timescale 1ns/1ps
module sim_txd_dom_guard;
  localparam int unsigned TO_T = 8;
  localparam int unsigned RA_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txdIn = 1'b1;
  logic normalActive = 1'b0;
  logic tick = 1'b0;
  logic drvDominant, timeoutFlag;

  int checks = 0;
  int fails  = 0;
  string curTag = "R6";

  // reference state: 0 off, 1 armed, 2 locked
  int mMode = 0;
  int mLow = 0;
  int mHigh = 0;
  bit mFlag = 1'b0;

  always #2 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_TICKS(TO_T), .REARM_TICKS(RA_T)) u0 (
    .clk(clk), .rst_n(rst_n), .txdIn(txdIn), .normalActive(normalActive),
    .tick(tick), .drvDominant(drvDominant), .timeoutFlag(timeoutFlag)
  );

  function automatic bit expDrv(bit nrm, int md, bit txd);
    return nrm && (md == 1) && !txd;
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(bit txd, bit nrm, bit tk);
    if (!nrm) begin
      mMode = 0; mLow = 0; mHigh = 0; mFlag = 0;
    end else if (mMode == 0) begin
      mMode = txd ? 1 : 2; mLow = 0; mHigh = 0;
    end else if (mMode == 1) begin
      if (txd) mLow = 0;
      else if (tk) begin
        mLow++;
        if (mLow >= TO_T) begin mMode = 2; mFlag = 1; mLow = 0; mHigh = 0; end
      end
    end else begin
      if (!txd) mHigh = 0;
      else if (tk) begin
        mHigh++;
        if (mHigh >= RA_T) begin mMode = 1; mFlag = 0; mLow = 0; mHigh = 0; end
      end
    end
  endtask

  task automatic step(bit txd, bit nrm, bit tk);
    string dTag;
    @(negedge clk);
    txdIn = txd; normalActive = nrm; tick = tk;
    #1;
    if (!nrm) dTag = "R5";
    else if (mMode == 2) dTag = mFlag ? "R3" : "R4";
    else if (mMode == 0) dTag = "R5";
    else dTag = "R1";
    check(dTag, "drvDominant", drvDominant, expDrv(nrm, mMode, txd));
    check(curTag, "timeoutFlag", timeoutFlag, mFlag);
    @(posedge clk);
    modelStep(txd, nrm, tk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    bit t, n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    #1;
    check("R5", "reset drvDominant", drvDominant, 1'b0);
    check("R5", "reset timeoutFlag", timeoutFlag, 1'b0);
    rst_n = 1'b1;

    // R5: first cycle of normal mode recessive even with txd low
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    // R1: armed, txd passes through
    for (int i = 0; i < 4; i++) step(i[0], 1'b1, 1'b0);

    // R7: low with no ticks never times out
    curTag = "R7";
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b0);
    check("R7", "no time-out without ticks", timeoutFlag, 1'b0);

    // R8: a high cycle restarts the low count
    curTag = "R8";
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < TO_T - 1; i++) step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < TO_T - 1; i++) step(1'b0, 1'b1, 1'b1);
    check("R8", "no time-out after restart", timeoutFlag, 1'b0);

    // R2: one more tick completes the window
    curTag = "R2";
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    check("R2", "timeoutFlag after window", timeoutFlag, 1'b1);
    check("R2", "driver forced recessive", drvDominant, 1'b0);

    // R3/R6: broken high run does not re-arm
    curTag = "R6";
    for (int i = 0; i < RA_T - 1; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < RA_T - 1; i++) step(1'b1, 1'b1, 1'b1);
    check("R6", "flag held during broken re-arm", timeoutFlag, 1'b1);
    curTag = "R3";
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    check("R3", "re-armed drives dominant", drvDominant, 1'b1);
    check("R3", "flag cleared on re-arm", timeoutFlag, 1'b0);

    // R4: entry with txd low locks without flag
    curTag = "R4";
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1);
    check("R4", "entry lock keeps recessive", drvDominant, 1'b0);
    check("R4", "entry lock no flag", timeoutFlag, 1'b0);
    for (int i = 0; i < RA_T; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    check("R4", "entry lock released", drvDominant, 1'b1);

    // R5: drop normal mode during a time-out
    curTag = "R5";
    for (int i = 0; i < TO_T; i++) step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R5", "flag cleared when normal off", timeoutFlag, 1'b0);

    // random mix
    curTag = "R6";
    t = 1'b1; n = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(11) == 0) t = ~t;
      if ($urandom_range(299) == 0) n = ~n;
      if (!n && $urandom_range(3) == 0) n = 1'b1;
      step(t, n, 1'($urandom_range(1)));
    end
    summary();
  end
endmodule